// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block turns one block-transfer command (a 16-entry register mask, a base address, the index of the base register and the direction, indexing, writeback, load/store and privileged-bank flags) into a stream of single-word memory accesses. Each access carries an address, the register index it moves, a read/write flag and a sequential/non-sequential type. Accesses always run in ascending register order with the lowest register at the lowest address. Descending transfers are handled by first computing the lowest address of the block and then walking upward with the indexing sense inverted.

When the last access has been accepted, the block pulses `done` and presents the new base value with its writeback enable. For stores it tells the datapath when the store data must be replaced: by the original base, by the final base or by the program counter value ahead of the instruction. It also reports when the program counter was loaded (`flush`), when saved status must be copied to current status (`psr_restore`) and, during the transfer, when the user register bank must be used (`user_bank`). The register file, the memory and the bank switching itself are outside the block.

Both the command input and the access output are valid/ready. A command is accepted only while the block is idle (`cmd_ready` high), and its fields are sampled in the accepting cycle only. An access is presented with `acc_valid` and completes in a cycle where `acc_ready` is high. While `acc_ready` is low, every access field stays unchanged.

Top module: `blkx_seq`

## Requirements
- R1: Accesses go in ascending register index order, one per accepted access. The first access is at the start address, and each later access is 4 bytes higher than the one before it.
- R2: When `cmd_up`=1 (ascending), the start address is base+4 if `cmd_pre`=1, and base otherwise. The final base is base + 4·n, where n is the number of set bits in the mask.
- R3: When `cmd_up`=0 (descending) with a non-empty mask, the lowest address is base − 4·n. The start address is that value if `cmd_pre`=1, and that value + 4 if `cmd_pre`=0. The final base is base − 4·n.
- R4: `done` pulses in the cycle after the last access is accepted, and `wb_value` then shows the final base. `wb_en` is high only in that cycle, and only if `cmd_wb`=1 and the command is not a load whose mask contains the base register.
- R5: On a store, an access of the base register sets `acc_ovr`. `acc_ovr_data` is then the original base if that register is the first one transferred, and the final base otherwise.
- R6: On a store, an access of register 15 that is not the base register sets `acc_ovr`, with `acc_ovr_data` = `cmd_insn_addr` + 12.
- R7: The first access of every command has `acc_seq`=0 (non-sequential). Every later access has `acc_seq`=1.
- R8: An empty mask produces a single access of register 15 at the unmodified base address, whatever the direction, and the final base is base + 0x40. On a load this access has `acc_clr_low2`=1, which tells the datapath to clear bits 1:0 of the loaded value.
- R9: With `cmd_sbit`=1, `user_bank` is high during the accesses of a store, and of a load whose mask bit 15 is clear. A load with mask bit 15 set instead keeps `user_bank` low and pulses `psr_restore` together with `flush`.
- R10: `flush` pulses in the cycle after a load access of register 15 is accepted. Such a pulse always coincides with `done`.
- R11: `cmd_ready` is high only while no access is pending. While `acc_valid`=1 and `acc_ready`=0, the address and register index hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_list | input | 16 | Register mask, bit i = register i |
| cmd_base | input | 32 | Base address value |
| cmd_base_idx | input | 4 | Index of the base register |
| cmd_insn_addr | input | 32 | Address of the transfer instruction |
| cmd_up | input | 1 | 1 = ascending, 0 = descending |
| cmd_pre | input | 1 | 1 = step before access, 0 = after |
| cmd_wb | input | 1 | Base writeback requested |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_sbit | input | 1 | Privileged bank/status flag |
| acc_valid | output | 1 | Access presented |
| acc_ready | input | 1 | Memory takes the access |
| acc_addr | output | 32 | Word address of the access |
| acc_reg | output | 4 | Register moved by the access |
| acc_write | output | 1 | 1 = memory write |
| acc_seq | output | 1 | 1 = sequential, 0 = non-sequential |
| acc_last | output | 1 | Final access of the command |
| acc_ovr | output | 1 | Store data comes from acc_ovr_data |
| acc_ovr_data | output | 32 | Replacement store data |
| acc_clr_low2 | output | 1 | Loaded value must have bits 1:0 cleared |
| user_bank | output | 1 | Use user register bank for this transfer |
| psr_restore | output | 1 | Copy saved status to current status |
| flush | output | 1 | Program counter was loaded |
| done | output | 1 | Command finished |
| wb_en | output | 1 | Write wb_value to the base register |
| wb_value | output | 32 | Final base value |

## Verification
The ordering and stepping properties assume that the mask selects distinct registers, so consecutive register indices can only grow, and that `acc_ready` may be held low for any number of cycles. The flush-implies-done property relies on register 15 being the highest index, so a load of it is always the final access. The stimulus offers each command only while `cmd_ready` is high and keeps `acc_ready` high except for a deliberate one-cycle stall. It also uses a base register other than 15 in every command, so the override for the base register and the one for the program counter never both apply to the same access.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  // Source of the data for a store access
  typedef enum logic [1:0] {
    SRC_REGFILE    = 2'd0,
    SRC_ORIG_BASE  = 2'd1,
    SRC_FINAL_BASE = 2'd2,
    SRC_PC_AHEAD   = 2'd3
  } store_src_e;

endpackage

// File: rtl/blkx_plan.sv
// Command decode: start address, final base and transfer attributes.
module blkx_plan #(
  parameter int AW       = 32,
  parameter int NREG     = 16,
  parameter int STEP     = 4,
  parameter int PC_AHEAD = 12,
  localparam int IW      = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic [IW-1:0]   base_idx,
  input  logic [AW-1:0]   insn_addr,
  input  logic            up,
  input  logic            pre,
  input  logic            wb,
  input  logic            load,
  input  logic            sbit,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_base,
  output logic [NREG-1:0] walk_list,
  output logic            wb_en,
  output logic            user_bank,
  output logic            psr_restore,
  output logic            empty,
  output logic [AW-1:0]   pc_value
);
  localparam int CW = $clog2(NREG + 1);
  localparam int PC_IDX = NREG - 1;
  localparam logic [AW-1:0] STEP_W     = AW'(STEP);
  localparam logic [AW-1:0] EMPTY_SPAN = AW'(NREG * STEP);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span, low_addr;
  logic          step_first, has_pc;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(list[i]);
  end

  assign span   = AW'(cnt) * STEP_W;
  assign empty  = (list == '0);
  assign has_pc = list[PC_IDX];

  // Descending: start from the bottom of the block and invert the step sense
  assign low_addr   = up ? base : (base - span);
  assign step_first = up ? pre : !pre;

  always_comb begin
    if (empty) begin
      walk_list  = NREG'(1) << PC_IDX;
      first_addr = base;
      final_base = base + EMPTY_SPAN;
    end else begin
      walk_list  = list;
      first_addr = low_addr + (step_first ? STEP_W : '0);
      final_base = up ? (base + span) : (base - span);
    end
  end

  assign wb_en       = wb && !(load && list[base_idx]);
  assign user_bank   = sbit && (!load || !has_pc);
  assign psr_restore = sbit && load && has_pc;
  assign pc_value    = insn_addr + AW'(PC_AHEAD);

endmodule

// File: rtl/blkx_pick.sv
// Lowest set bit of the remaining mask, and whether it is the only one.
module blkx_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  output logic [IW-1:0]   idx,
  output logic            last
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (list[i]) idx = IW'(i);
    end
  end

  assign last = ((list & (list - NREG'(1))) == '0);

endmodule

// File: rtl/blkx_store_src.sv
// Chooses replacement data for store accesses.
module blkx_store_src #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [IW-1:0] cur_idx,
  input  logic [IW-1:0] base_idx,
  input  logic          first,
  input  logic          is_store,
  input  logic [AW-1:0] orig_base,
  input  logic [AW-1:0] final_base,
  input  logic [AW-1:0] pc_value,
  output logic          ovr,
  output logic [AW-1:0] ovr_data
);
  import blkx_pkg::*;
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  store_src_e src;

  always_comb begin
    src = SRC_REGFILE;
    if (is_store) begin
      if (cur_idx == base_idx)    src = first ? SRC_ORIG_BASE : SRC_FINAL_BASE;
      else if (cur_idx == PC_IDX) src = SRC_PC_AHEAD;
    end
  end

  always_comb begin
    unique case (src)
      SRC_ORIG_BASE:  ovr_data = orig_base;
      SRC_FINAL_BASE: ovr_data = final_base;
      SRC_PC_AHEAD:   ovr_data = pc_value;
      default:        ovr_data = '0;
    endcase
  end

  assign ovr = (src != SRC_REGFILE);

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq #(
  parameter int AW       = 32,
  parameter int NREG     = 16,
  parameter int STEP     = 4,
  parameter int PC_AHEAD = 12,
  localparam int IW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_list,
  input  logic [AW-1:0]   cmd_base,
  input  logic [IW-1:0]   cmd_base_idx,
  input  logic [AW-1:0]   cmd_insn_addr,
  input  logic            cmd_up,
  input  logic            cmd_pre,
  input  logic            cmd_wb,
  input  logic            cmd_load,
  input  logic            cmd_sbit,
  output logic            acc_valid,
  input  logic            acc_ready,
  output logic [AW-1:0]   acc_addr,
  output logic [IW-1:0]   acc_reg,
  output logic            acc_write,
  output logic            acc_seq,
  output logic            acc_last,
  output logic            acc_ovr,
  output logic [AW-1:0]   acc_ovr_data,
  output logic            acc_clr_low2,
  output logic            user_bank,
  output logic            psr_restore,
  output logic            flush,
  output logic            done,
  output logic            wb_en,
  output logic [AW-1:0]   wb_value
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  // Decoded command
  logic [AW-1:0]   p_first, p_final, p_pc;
  logic [NREG-1:0] p_walk;
  logic            p_wb_en, p_ub, p_psr, p_empty;

  blkx_plan #(.AW(AW), .NREG(NREG), .STEP(STEP), .PC_AHEAD(PC_AHEAD)) u_plan (
    .list(cmd_list), .base(cmd_base), .base_idx(cmd_base_idx),
    .insn_addr(cmd_insn_addr), .up(cmd_up), .pre(cmd_pre), .wb(cmd_wb),
    .load(cmd_load), .sbit(cmd_sbit), .first_addr(p_first),
    .final_base(p_final), .walk_list(p_walk), .wb_en(p_wb_en),
    .user_bank(p_ub), .psr_restore(p_psr), .empty(p_empty), .pc_value(p_pc)
  );

  // Walk state
  logic            busy_q, first_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, orig_q, final_q, pc_q;
  logic [IW-1:0]   bidx_q;
  logic            load_q, ub_q, psr_sel_q, empty_q, wb_sel_q;
  logic            done_q, flush_q, psr_q;

  logic [IW-1:0]   cur_idx;
  logic            cur_last;
  logic            cmd_fire, acc_fire, pc_load_fire;

  blkx_pick #(.NREG(NREG)) u_pick (
    .list(rem_q), .idx(cur_idx), .last(cur_last)
  );

  blkx_store_src #(.AW(AW), .NREG(NREG)) u_src (
    .cur_idx(cur_idx), .base_idx(bidx_q), .first(first_q),
    .is_store(busy_q && !load_q), .orig_base(orig_q), .final_base(final_q),
    .pc_value(pc_q), .ovr(acc_ovr), .ovr_data(acc_ovr_data)
  );

  assign cmd_ready    = !busy_q;
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign acc_valid    = busy_q;
  assign acc_fire     = acc_valid && acc_ready;
  assign pc_load_fire = acc_fire && load_q && (cur_idx == PC_IDX);

  assign acc_addr     = addr_q;
  assign acc_reg      = cur_idx;
  assign acc_write    = busy_q && !load_q;
  assign acc_seq      = busy_q && !first_q;
  assign acc_last     = busy_q && cur_last;
  assign acc_clr_low2 = busy_q && load_q && empty_q;
  assign user_bank    = busy_q && ub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      first_q   <= 1'b0;
      rem_q     <= '0;
      addr_q    <= '0;
      orig_q    <= '0;
      final_q   <= '0;
      pc_q      <= '0;
      bidx_q    <= '0;
      load_q    <= 1'b0;
      ub_q      <= 1'b0;
      psr_sel_q <= 1'b0;
      empty_q   <= 1'b0;
      wb_sel_q  <= 1'b0;
    end else if (cmd_fire) begin
      busy_q    <= 1'b1;
      first_q   <= 1'b1;
      rem_q     <= p_walk;
      addr_q    <= p_first;
      orig_q    <= cmd_base;
      final_q   <= p_final;
      pc_q      <= p_pc;
      bidx_q    <= cmd_base_idx;
      load_q    <= cmd_load;
      ub_q      <= p_ub;
      psr_sel_q <= p_psr;
      empty_q   <= p_empty;
      wb_sel_q  <= p_wb_en;
    end else if (acc_fire) begin
      rem_q   <= rem_q & (rem_q - NREG'(1));
      addr_q  <= addr_q + STEP_W;
      first_q <= 1'b0;
      if (cur_last) busy_q <= 1'b0;
    end
  end

  // Completion pulses, one cycle after the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      psr_q   <= 1'b0;
    end else begin
      done_q  <= acc_fire && cur_last;
      flush_q <= pc_load_fire;
      psr_q   <= pc_load_fire && psr_sel_q;
    end
  end

  assign done        = done_q;
  assign flush       = flush_q;
  assign psr_restore = psr_q;
  assign wb_en       = done_q && wb_sel_q;
  assign wb_value    = final_q;

  // Stepping and ordering of the access stream
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_last |=> acc_valid && (acc_addr == $past(acc_addr) + STEP_W));
  p_reg_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_last |=> acc_reg > $past(acc_reg));

  // Access type
  p_later_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_last |=> acc_seq);
  p_first_nonseq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !acc_seq);

  // Back-pressure and command acceptance
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_reg));
  p_idle_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !acc_valid);

  // Completion
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_last |=> done);
  p_wb_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  p_flush_is_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> done);
  p_restore_with_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> flush);
  p_empty_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_low2 |-> acc_last && (acc_reg == PC_IDX));

endmodule

// File: tb/blkx_seq_bench.sv
module blkx_seq_bench;

  typedef struct packed {
    logic [15:0] list;
    logic [31:0] base;
    logic [3:0]  idx;
    logic        up, pre, wb, load, s;
    logic [31:0] first;
    logic [4:0]  n;
    logic        wben;
    logic [31:0] wbval;
  } xvec_t;

  localparam int NV = 14;
  localparam logic [31:0] INSN = 32'h0000_0800;

  // list, base, idx, up, pre, wb, load, s | first, n, wb_en, wb_value
  localparam xvec_t VECS [NV] = '{
    '{16'h000E, 32'h1000, 4'd0,  1'b1,1'b0,1'b1,1'b1,1'b0, 32'h1000, 5'd3,  1'b1, 32'h100C},
    '{16'h000E, 32'h1000, 4'd0,  1'b1,1'b1,1'b1,1'b1,1'b0, 32'h1004, 5'd3,  1'b1, 32'h100C},
    '{16'h000E, 32'h1000, 4'd0,  1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0FF4, 5'd3,  1'b1, 32'h0FF4},
    '{16'h000E, 32'h1000, 4'd0,  1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0FF8, 5'd3,  1'b1, 32'h0FF4},
    '{16'h0031, 32'h2000, 4'd4,  1'b1,1'b0,1'b1,1'b1,1'b0, 32'h2000, 5'd3,  1'b0, 32'h200C},
    '{16'h0031, 32'h2000, 4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 32'h2000, 5'd3,  1'b1, 32'h200C},
    '{16'h0011, 32'h3000, 4'd0,  1'b1,1'b1,1'b1,1'b0,1'b0, 32'h3004, 5'd2,  1'b1, 32'h3008},
    '{16'h0000, 32'h4000, 4'd1,  1'b1,1'b0,1'b1,1'b1,1'b0, 32'h4000, 5'd1,  1'b1, 32'h4040},
    '{16'h0000, 32'h5000, 4'd1,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5000, 5'd1,  1'b0, 32'h5040},
    '{16'hFFFF, 32'h8000, 4'd13, 1'b0,1'b1,1'b1,1'b1,1'b0, 32'h7FC0, 5'd16, 1'b0, 32'h7FC0},
    '{16'h8000, 32'h0100, 4'd2,  1'b1,1'b0,1'b1,1'b0,1'b1, 32'h0100, 5'd1,  1'b1, 32'h0104},
    '{16'h8003, 32'h0600, 4'd5,  1'b1,1'b0,1'b1,1'b1,1'b1, 32'h0600, 5'd3,  1'b1, 32'h060C},
    '{16'h0006, 32'h0700, 4'd0,  1'b1,1'b1,1'b0,1'b1,1'b1, 32'h0704, 5'd2,  1'b0, 32'h0708},
    '{16'h000C, 32'h0900, 4'd3,  1'b0,1'b0,1'b1,1'b0,1'b0, 32'h08FC, 5'd2,  1'b1, 32'h08F8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic [3:0]  cmd_base_idx = '0;
  logic [31:0] cmd_insn_addr = INSN;
  logic        cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wb = 1'b0, cmd_load = 1'b0, cmd_sbit = 1'b0;
  logic        acc_valid;
  logic        acc_ready = 1'b1;
  logic [31:0] acc_addr;
  logic [3:0]  acc_reg;
  logic        acc_write, acc_seq, acc_last, acc_ovr, acc_clr_low2;
  logic [31:0] acc_ovr_data;
  logic        user_bank, psr_restore, flush, done, wb_en;
  logic [31:0] wb_value;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  blkx_seq u_blkx_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_list(cmd_list),
    .cmd_base(cmd_base), .cmd_base_idx(cmd_base_idx), .cmd_insn_addr(cmd_insn_addr),
    .cmd_up(cmd_up), .cmd_pre(cmd_pre), .cmd_wb(cmd_wb), .cmd_load(cmd_load),
    .cmd_sbit(cmd_sbit),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_reg(acc_reg), .acc_write(acc_write), .acc_seq(acc_seq),
    .acc_last(acc_last), .acc_ovr(acc_ovr), .acc_ovr_data(acc_ovr_data),
    .acc_clr_low2(acc_clr_low2), .user_bank(user_bank),
    .psr_restore(psr_restore), .flush(flush), .done(done),
    .wb_en(wb_en), .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input xvec_t v, input bit stall);
    logic [15:0] rem;
    logic [3:0]  ereg;
    logic [31:0] a0, eovr;
    bit          eo, fin, exp_ub, exp_flush, exp_psr, exp_clr;
    int          n;
    rem       = (v.list == 16'h0) ? 16'h8000 : v.list;
    exp_ub    = v.s && (!v.load || !v.list[15]);
    exp_psr   = v.s && v.load && v.list[15];
    exp_flush = v.load && ((v.list == 16'h0) || v.list[15]);
    exp_clr   = v.load && (v.list == 16'h0);
    @(negedge clk);
    chk(cmd_ready, "R11 idle ready", {31'd0, cmd_ready}, 32'd1);
    cmd_list = v.list; cmd_base = v.base; cmd_base_idx = v.idx;
    cmd_up = v.up; cmd_pre = v.pre; cmd_wb = v.wb; cmd_load = v.load; cmd_sbit = v.s;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    chk(!cmd_ready, "R11 busy not ready", {31'd0, cmd_ready}, 32'd0);
    if (stall) begin
      acc_ready = 1'b0;
      a0 = acc_addr;
      @(negedge clk);
      chk(acc_valid && acc_addr == a0 && !acc_seq, "R11 hold under stall", acc_addr, a0);
      acc_ready = 1'b1;
    end
    n = 0;
    fin = 1'b0;
    for (int g = 0; g < 40 && !fin; g++) begin
      ereg = 4'd0;
      for (int i = 15; i >= 0; i--) if (rem[i]) ereg = 4'(i);
      rem[ereg] = 1'b0;
      chk(acc_valid, "R1 access present", {31'd0, acc_valid}, 32'd1);
      chk(acc_addr == v.first + 32'(4 * n), "R1 address", acc_addr, v.first + 32'(4 * n));
      chk(acc_reg == ereg, "R1 register order", {28'd0, acc_reg}, {28'd0, ereg});
      chk(acc_seq == (n != 0), "R7 access type", {31'd0, acc_seq}, {31'd0, n != 0});
      chk(acc_write == !v.load, "R1 direction", {31'd0, acc_write}, {31'd0, !v.load});
      chk(user_bank == exp_ub, "R9 user bank", {31'd0, user_bank}, {31'd0, exp_ub});
      chk(acc_clr_low2 == exp_clr, "R8 clear low bits", {31'd0, acc_clr_low2}, {31'd0, exp_clr});
      eo = 1'b0; eovr = 32'h0;
      if (!v.load && ereg == v.idx) begin
        eo = 1'b1; eovr = (n == 0) ? v.base : v.wbval;
      end else if (!v.load && ereg == 4'd15) begin
        eo = 1'b1; eovr = INSN + 32'd12;
      end
      if (ereg == v.idx) chk(acc_ovr == eo && (!eo || acc_ovr_data == eovr),
                             "R5 base store data", acc_ovr_data, eovr);
      else if (ereg == 4'd15) chk(acc_ovr == eo && (!eo || acc_ovr_data == eovr),
                                  "R6 pc store data", acc_ovr_data, eovr);
      else chk(!acc_ovr, "R5 no override", {31'd0, acc_ovr}, 32'd0);
      fin = acc_last;
      chk(acc_last == (rem == 16'h0), "R1 last flag", {31'd0, acc_last}, {31'd0, rem == 16'h0});
      @(negedge clk);
      n++;
    end
    chk(n == int'(v.n), "R2 access count", 32'(n), {27'd0, v.n});
    chk(done, "R4 done pulse", {31'd0, done}, 32'd1);
    chk(wb_en == v.wben, "R4 writeback enable", {31'd0, wb_en}, {31'd0, v.wben});
    chk(wb_value == v.wbval, v.up ? "R2 final base" : "R3 final base", wb_value, v.wbval);
    chk(flush == exp_flush, "R10 flush", {31'd0, flush}, {31'd0, exp_flush});
    chk(psr_restore == exp_psr, "R9 status restore", {31'd0, psr_restore}, {31'd0, exp_psr});
    @(negedge clk);
    chk(!done && !wb_en && !flush, "R4 single pulse", {29'd0, done, wb_en, flush}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !acc_valid && !done && !wb_en && !flush && !user_bank && !psr_restore,
        "R11 reset state", {25'd0, cmd_ready, acc_valid, done, wb_en, flush, user_bank,
        psr_restore}, 32'h40);
    rst_n = 1'b1;
    @(negedge clk);
    // Table walk: R2 R3 R5 R6 R8 R9 R10 cases
    for (int k = 0; k < NV; k++) run_xfer(VECS[k], 1'b0);
    // Directed: back-pressure on the first access (R11, R7)
    run_xfer(VECS[3], 1'b1);
    // Directed: back-pressure on an empty-list load (R8, R11)
    run_xfer(VECS[7], 1'b1);
    // Directed: idle block with no command stays quiet
    repeat (3) @(negedge clk);
    chk(!acc_valid && !done, "R11 idle quiet", {30'd0, acc_valid, done}, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule